// File: doc/BRIEF.md
# Strobe-Counted Boot Overlay Chip-Select Decoder

This block generates the chip selects for a processor with an 8-bit data bus and a 22-bit address bus. It compares each bus address against four fixed windows: main RAM at the bottom of the 4 MB space, ROM above RAM, an 8 KB dual-UART window and an 8 KB expansion window at the top. For each window it drives one active-low select. A select is driven only while the address strobe is low.

After reset the processor fetches its initial stack pointer and program counter from address zero. At that moment RAM there holds nothing useful. To cover this, the block keeps a boot flag raised for the first eight bus cycles after reset. It counts these cycles on the deasserting (rising) edge of the active-low address strobe, sampled on the system clock. While the flag is raised, reads anywhere in the RAM window select ROM instead, and writes there select nothing. The ROM offset comes from the low address bits. Once the eighth strobe has ended, the flag drops and RAM answers at address zero. The flag is also brought out as a port.

Top module: `boot_overlay_decoder`

## Requirements
- R1: With the boot flag low and the strobe low, an address from 0x000000 to 0x37FFFF drives only ramSelN low, for both reads (rwN=1) and writes (rwN=0).
- R2: With the strobe low, an address from 0x380000 to 0x3FBFFF drives only romSelN low.
- R3: With the strobe low, an address from 0x3FC000 to 0x3FDFFF drives only uartSelN low.
- R4: With the strobe low, an address from 0x3FE000 to 0x3FFFFF drives only expSelN low.
- R5: While asN is high, all four selects are high.
- R6: No more than one select is low at any time.
- R7: bootActive is high from reset. It falls on the first clock edge at which asN is sampled high after the eighth low-to-high transition of asN since reset. After that it stays low until the next reset.
- R8: While bootActive is high, a read (rwN=1) with the strobe low at an address from 0x000000 to 0x37FFFF drives romSelN low and leaves ramSelN high.
- R9: While bootActive is high, a write (rwN=0) at an address from 0x000000 to 0x37FFFF leaves all four selects high.
- R10: Asserting rstN low at any time, including partway through the boot cycles, clears the strobe count and raises bootActive again. A full set of eight strobes is then needed before it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the address strobe |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 22 | Processor address bus |
| asN | input | 1 | Active-low address strobe |
| rwN | input | 1 | High for read, low for write |
| ramSelN | output | 1 | Active-low RAM select |
| romSelN | output | 1 | Active-low ROM select |
| uartSelN | output | 1 | Active-low dual-UART select |
| expSelN | output | 1 | Active-low expansion-region select |
| bootActive | output | 1 | High while the boot overlay is in force |

## Verification
The bench steps on every window edge: 0x37FFFF/0x380000, 0x3FBFFF/0x3FC000, 0x3FDFFF/0x3FE000 and 0x3FFFFF. An off-by-one compare there would select the wrong device, or two devices at once. It runs exactly eight strobes and then a ninth. A counter that drops the flag one cycle early would hand a vector fetch to RAM, and one that drops it late would block the first RAM access. It issues reads and writes in the low region during boot, which exposes an overlay that ignores the direction bit. It also resets partway through boot, which catches a counter that keeps its old count.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;
  // Strobes passed from the boot control to the select datapath
  typedef struct packed {
    logic bootActive;  // overlay in force
    logic busActive;   // address strobe asserted
  } bootStrobe_t;
endpackage

// File: rtl/boot_strobe_ctrl.sv
module boot_strobe_ctrl
  import boot_overlay_pkg::*;
#(
  parameter int BOOT_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        asN,
  output bootStrobe_t strobes
);
  localparam int CNT_W = $clog2(BOOT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(BOOT_CYCLES);

  logic [CNT_W-1:0] strobeCount;
  logic             asPrev;
  logic             strobeEnd;

  assign strobeEnd = asN && !asPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeCount <= '0;
      asPrev      <= 1'b1;
    end else begin
      asPrev <= asN;
      if (strobeEnd && (strobeCount != CNT_LIMIT))
        strobeCount <= strobeCount + 1'b1;
    end
  end

  always_comb begin
    strobes.bootActive = (strobeCount != CNT_LIMIT);
    strobes.busActive  = !asN;
  end

  // R7
  boot_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.bootActive) |-> ($past(asN) && !$past(asPrev)));

  // R10
  boot_rearm_chk: assert property (@(posedge clk)
    !rstN |=> strobes.bootActive);
endmodule

// File: rtl/boot_select_path.sv
module boot_select_path
  import boot_overlay_pkg::*;
#(
  parameter int          ADDR_W    = 22,
  parameter logic [21:0] RAM_LAST  = 22'h37FFFF,
  parameter logic [21:0] ROM_LAST  = 22'h3FBFFF,
  parameter logic [21:0] UART_LAST = 22'h3FDFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rwN,
  input  bootStrobe_t       strobes,
  output logic              ramSelN,
  output logic              romSelN,
  output logic              uartSelN,
  output logic              expSelN
);
  localparam logic [ADDR_W-1:0] RAM_TOP  = ADDR_W'(RAM_LAST);
  localparam logic [ADDR_W-1:0] ROM_TOP  = ADDR_W'(ROM_LAST);
  localparam logic [ADDR_W-1:0] UART_TOP = ADDR_W'(UART_LAST);

  logic inRam, inRom, inUart, inExp;
  logic overlayRead;

  always_comb begin
    inRam  = (addr <= RAM_TOP);
    inRom  = !inRam && (addr <= ROM_TOP);
    inUart = !inRam && !inRom && (addr <= UART_TOP);
    inExp  = !inRam && !inRom && !inUart;
    overlayRead = strobes.bootActive && rwN;

    ramSelN  = !(strobes.busActive && inRam && !strobes.bootActive);
    romSelN  = !(strobes.busActive && (inRom || (inRam && overlayRead)));
    uartSelN = !(strobes.busActive && inUart);
    expSelN  = !(strobes.busActive && inExp);
  end

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.busActive |-> (ramSelN && romSelN && uartSelN && expSelN));

  // R6
  one_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!ramSelN, !romSelN, !uartSelN, !expSelN}));

  // R8
  vector_rom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busActive && strobes.bootActive && rwN && addr <= RAM_TOP)
      |-> (!romSelN && ramSelN));

  // R9
  boot_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bootActive && !rwN && addr <= RAM_TOP)
      |-> (ramSelN && romSelN && uartSelN && expSelN));
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_overlay_pkg::*;
#(
  parameter int BOOT_CYCLES = 8,
  parameter int ADDR_W      = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              asN,
  input  logic              rwN,
  output logic              ramSelN,
  output logic              romSelN,
  output logic              uartSelN,
  output logic              expSelN,
  output logic              bootActive
);
  bootStrobe_t strobes;

  boot_strobe_ctrl #(.BOOT_CYCLES(BOOT_CYCLES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .asN     (asN),
    .strobes (strobes)
  );

  boot_select_path #(.ADDR_W(ADDR_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .rwN      (rwN),
    .strobes  (strobes),
    .ramSelN  (ramSelN),
    .romSelN  (romSelN),
    .uartSelN (uartSelN),
    .expSelN  (expSelN)
  );

  assign bootActive = strobes.bootActive;
endmodule

// File: tb/boot_overlay_decoder_test.sv
module boot_overlay_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] addr = '0;
  logic        asN = 1'b1;
  logic        rwN = 1'b1;
  logic        ramSelN, romSelN, uartSelN, expSelN, bootActive;

  int vectors = 0;
  int errors  = 0;
  int modelCount = 0;
  bit modelPrevAs = 1'b1;
  string bootTag = "R7";

  always #2 clk = ~clk;  // 250 MHz

  boot_overlay_decoder uut (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .rwN(rwN),
    .ramSelN(ramSelN), .romSelN(romSelN), .uartSelN(uartSelN),
    .expSelN(expSelN), .bootActive(bootActive)
  );

  // Behavioural reference: count strobe ends seen at clock edges
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelCount  = 0;
      modelPrevAs = 1'b1;
    end else begin
      if (asN && !modelPrevAs && modelCount < 8) modelCount++;
      modelPrevAs = asN;
    end
  end

  task automatic compare();
    bit  expBoot;
    bit [3:0] expSel;  // {ram, rom, uart, exp}, active high
    string tag;
    expBoot = (modelCount < 8);
    expSel = 4'b0000;
    if (asN) tag = "R5";
    else if (addr <= 22'h37FFFF) begin
      if (expBoot && rwN)       begin expSel = 4'b0100; tag = "R8"; end
      else if (expBoot)         tag = "R9";
      else                      begin expSel = 4'b1000; tag = "R1"; end
    end
    else if (addr <= 22'h3FBFFF) begin expSel = 4'b0100; tag = "R2"; end
    else if (addr <= 22'h3FDFFF) begin expSel = 4'b0010; tag = "R3"; end
    else                         begin expSel = 4'b0001; tag = "R4"; end

    vectors++;
    if ({!ramSelN, !romSelN, !uartSelN, !expSelN} !== expSel) begin
      errors++;
      $display("FAIL %s addr=%h rwN=%b: selects %b expected %b", tag, addr, rwN,
               {!ramSelN, !romSelN, !uartSelN, !expSelN}, expSel);
    end
    if ($countones({!ramSelN, !romSelN, !uartSelN, !expSelN}) > 1) begin
      errors++;
      $display("FAIL R6 addr=%h: selects %b expected at most one low", addr,
               {ramSelN, romSelN, uartSelN, expSelN});
    end
    if (bootActive !== expBoot) begin
      errors++;
      $display("FAIL %s bootActive %b expected %b (count %0d)", bootTag,
               bootActive, expBoot, modelCount);
    end
  endtask

  task automatic step(input logic [21:0] a, input logic as, input logic rw);
    @(negedge clk);
    addr = a; asN = as; rwN = rw;
    #1 compare();
  endtask

  task automatic busCycle(input logic [21:0] a, input logic rw);
    step(a, 1'b0, rw);
    step(a, 1'b0, rw);
    step(a, 1'b1, rw);
  endtask

  initial begin
    // reset state
    step(22'h000000, 1'b1, 1'b1);
    step(22'h000000, 1'b0, 1'b1);
    @(negedge clk); rstN = 1'b1;
    // R7 / R8 / R9: eight boot cycles, mixed accesses
    busCycle(22'h000000, 1'b1);
    busCycle(22'h000002, 1'b1);
    busCycle(22'h000004, 1'b1);
    busCycle(22'h000010, 1'b0);
    busCycle(22'h37FFFF, 1'b1);
    busCycle(22'h380000, 1'b1);
    busCycle(22'h3FC000, 1'b0);
    busCycle(22'h000400, 1'b1);
    // R1..R4 boundaries after boot
    busCycle(22'h000000, 1'b1);
    busCycle(22'h000000, 1'b0);
    busCycle(22'h37FFFF, 1'b0);
    busCycle(22'h380000, 1'b1);
    busCycle(22'h3FBFFF, 1'b1);
    busCycle(22'h3FC000, 1'b1);
    busCycle(22'h3FDFFF, 1'b0);
    busCycle(22'h3FE000, 1'b1);
    busCycle(22'h3FFFFF, 1'b0);
    for (int i = 0; i < 16; i++) busCycle(22'(i * 22'h03F0A1), i[0]);
    // R10: reset partway through a new boot
    bootTag = "R10";
    @(negedge clk); rstN = 1'b0;
    step(22'h000000, 1'b1, 1'b1);
    @(negedge clk); rstN = 1'b1;
    busCycle(22'h000000, 1'b1);
    busCycle(22'h000002, 1'b1);
    busCycle(22'h000100, 1'b0);
    @(negedge clk); rstN = 1'b0;
    step(22'h000000, 1'b1, 1'b1);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 9; i++) busCycle(22'(i * 4), 1'b1);
    busCycle(22'h3FE004, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule